// File: doc/BRIEF.md
# Bit-Serial Adder with Carry Flip-Flop

This block adds two 8-bit operands one bit position per clock, using a single full-adder cell for every position. A start pulse captures both operands into shift registers and clears the carry. Over the next eight clocks the two least significant operand bits and the stored carry go into the full adder. Its sum bit shifts into the result register from the top, and its carry-out is stored in a flip-flop that feeds the next bit position.

When the eighth position has been processed, a one-cycle done pulse marks that the result register holds the 8-bit sum and the carry flip-flop holds the carry out of bit 7. Both hold their values until the next accepted start. While idle, a clear input can zero the carry flip-flop. The block suits datapaths where area matters more than latency, since one adder cell takes the place of a full ripple chain.

Top module: `bit_serial_adder`

## Requirements
- R1: After reset is asserted, z_o is 0x00, and cout_o, busy_o and done_o are 0.
- R2: A start_i sampled high while busy_o is low captures x_i and y_i and zeroes the carry. busy_o is high in the following cycle and cout_o is 0 there.
- R3: An addition takes exactly WIDTH (8) shift clocks after the start clock, bit 0 first. busy_o stays high for exactly 8 cycles.
- R4: done_o is high for exactly one cycle, the cycle that follows the eighth shift clock, which is the 8th clock after the start clock. busy_o is low in that cycle.
- R5: While done_o is high, z_o equals (x + y) mod 256 and cout_o equals bit 8 of the 9-bit sum x + y.
- R6: A start_i while busy_o is high is ignored. The running addition completes on schedule with the originally captured operands.
- R7: While idle, with no start and no clear, z_o and cout_o keep the values they had at done.
- R8: clr_carry_i sampled high while idle drives cout_o to 0 on the next clock and leaves z_o unchanged. While busy, clr_carry_i has no effect on the result.
- R9: When start_i and clr_carry_i are both high while idle, the start is taken: the addition begins and completes as in R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load operands, clear carry and begin an addition |
| clr_carry_i | input | 1 | Zero the carry flip-flop while idle |
| x_i | input | 8 | First operand, captured on start |
| y_i | input | 8 | Second operand, captured on start |
| busy_o | output | 1 | Addition in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| z_o | output | 8 | Sum, bits 7..0 |
| cout_o | output | 1 | Carry flip-flop; carry out of bit 7 after done |

## Verification
busy_o is due one clock after the start clock. The sum, the carry-out and the done pulse are all due in the cycle after the eighth shift clock, which is eight clocks after the start clock. A clear of the carry takes effect one clock after it is sampled. The bench drives inputs on falling edges and counts rising edges from the start clock. It samples on the falling edge of the cycle in which each result is due, and checks one cycle later that done_o has dropped and that the held values are unchanged.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bsa_state_e;
endpackage

// File: rtl/bsa_shift_reg.sv
module bsa_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             lsb_o
);
  logic [WIDTH-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (load_i)   q <= data_i;
    else if (shift_i)  q <= {1'b0, q[WIDTH-1:1]};
  end

  assign lsb_o = q[0];
endmodule

// File: rtl/bsa_full_adder.sv
module bsa_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  assign p   = a_i ^ b_i;
  assign s_o = p ^ c_i;
  assign c_o = (a_i & b_i) | (p & c_i);
endmodule

// File: rtl/bsa_carry_ff.sv
module bsa_carry_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (en_i)  q_o <= d_i;
  end
endmodule

// File: rtl/bsa_seq.sv
module bsa_seq
  import bsa_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic shift_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  bsa_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign load_o  = start_i && (state_q == ST_IDLE);
  assign shift_o = (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (load_o) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;
endmodule

// File: rtl/bsa_result_reg.sv
module bsa_result_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] q_o
);
  // sum bits enter at the MSB; after WIDTH shifts bit 0 sits at q_o[0]
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (shift_i) q_o <= {bit_i, q_o[WIDTH-1:1]};
  end
endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clr_carry_i,
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] z_o,
  output logic             cout_o
);
  localparam int N_OPND = 2;

  logic             load, shift;
  logic [WIDTH-1:0] opnd_d [N_OPND];
  logic [N_OPND-1:0] opnd_bit;
  logic             sum_bit, carry_nxt, carry_q, carry_clr;

  assign opnd_d[0] = x_i;
  assign opnd_d[1] = y_i;

  bsa_seq #(.WIDTH(WIDTH)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .shift_o (shift),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    bsa_shift_reg #(.WIDTH(WIDTH)) i_sreg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .shift_i (shift),
      .data_i  (opnd_d[g]),
      .lsb_o   (opnd_bit[g])
    );
  end

  bsa_full_adder i_fa (
    .a_i (opnd_bit[0]),
    .b_i (opnd_bit[1]),
    .c_i (carry_q),
    .s_o (sum_bit),
    .c_o (carry_nxt)
  );

  // start always clears; the external clear only acts while idle
  assign carry_clr = load | (clr_carry_i & ~busy_o);

  bsa_carry_ff i_cff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (carry_clr),
    .en_i   (shift),
    .d_i    (carry_nxt),
    .q_o    (carry_q)
  );

  bsa_result_reg #(.WIDTH(WIDTH)) i_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .bit_i   (sum_bit),
    .q_o     (z_o)
  );

  assign cout_o = carry_q;
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             clr_carry_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] z_o,
  input logic             cout_o
);
  localparam int RUN_W = $clog2(WIDTH + 1) + 1;
  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && !cout_o); // R2
  AST_RUN_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_cnt == RUN_W'(WIDTH)); // R3
  AST_DONE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R4
  AST_RUN_IGNORES_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && run_cnt < RUN_W'(WIDTH - 1) |=> busy_o); // R6
  AST_Z_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(z_o)); // R7
  AST_COUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i && !clr_carry_i |=> $stable(cout_o)); // R7
  AST_CLEAR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && clr_carry_i |=> !cout_o); // R8
endmodule

bind bit_serial_adder bsa_checker #(.WIDTH(WIDTH)) i_bsa_checker (.*);

// File: tb/test_bit_serial_adder.sv
`timescale 1ns/1ps
module test_bit_serial_adder;
  localparam int W = 8;
  localparam int N_VEC = 10;
  localparam logic [15:0] VEC [N_VEC] = '{
    16'hFF01, 16'h0000, 16'hFFFF, 16'h8080, 16'h0102,
    16'h7F01, 16'hA55A, 16'h3C4D, 16'hC3E7, 16'h0F0F
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         clr_carry_i = 1'b0;
  logic [W-1:0] x_i = '0;
  logic [W-1:0] y_i = '0;
  logic         busy_o, done_o, cout_o;
  logic [W-1:0] z_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bit_serial_adder #(.WIDTH(W)) i_bit_serial_adder (
    .clk_i, .rst_ni, .start_i, .clr_carry_i, .x_i, .y_i,
    .busy_o, .done_o, .z_o, .cout_o
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // start at one edge, wait eight shift edges, sample at the next falling edge
  task automatic add_pair(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit clr_too, input bit poke_busy);
    logic [8:0] exp;
    exp = {1'b0, a} + {1'b0, b};
    @(negedge clk_i);
    x_i = a; y_i = b; start_i = 1'b1; clr_carry_i = clr_too;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0; clr_carry_i = 1'b0;
    chk(busy_o && !cout_o, "R2 busy set, carry cleared", {14'b0, busy_o, cout_o}, 16'h0002);
    for (int i = 0; i < W; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (poke_busy && i == 2) begin
        x_i = ~a; y_i = 8'h5A; start_i = 1'b1; clr_carry_i = 1'b1;
      end else begin
        start_i = 1'b0; clr_carry_i = 1'b0;
      end
      if (i < W - 1)
        chk(busy_o && !done_o, "R3 busy during shift", {14'b0, busy_o, done_o}, 16'h0002);
    end
    chk(done_o && !busy_o, "R4 done after eighth shift", {14'b0, done_o, busy_o}, 16'h0002);
    chk({cout_o, z_o} == exp, poke_busy ? "R6 start while busy" :
        (clr_too ? "R9 start with clear" : "R5 sum and carry"),
        {7'b0, cout_o, z_o}, {7'b0, exp});
    @(negedge clk_i);
    chk(!done_o, "R4 done lasts one cycle", {15'b0, done_o}, 16'h0000);
    chk({cout_o, z_o} == exp, "R7 result held", {7'b0, cout_o, z_o}, {7'b0, exp});
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #12;
    chk(z_o == 0 && !cout_o && !busy_o && !done_o, "R1 reset state",
        {4'b0, busy_o, done_o, cout_o, 1'b0, z_o}, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int v = 0; v < N_VEC; v++)
      add_pair(VEC[v][15:8], VEC[v][7:0], 1'b0, 1'b0);

    // R7: hold over several idle cycles
    add_pair(8'hFF, 8'h01, 1'b0, 1'b0);
    repeat (5) @(negedge clk_i);
    chk({cout_o, z_o} == 9'h100, "R7 long hold", {7'b0, cout_o, z_o}, 16'h0100);

    // R8: idle clear zeroes carry, keeps sum
    clr_carry_i = 1'b1;
    @(negedge clk_i);
    clr_carry_i = 1'b0;
    chk(!cout_o && z_o == 8'h00, "R8 idle clear", {7'b0, cout_o, z_o}, 16'h0000);

    // R6 and R8: start and clear during a run are ignored
    add_pair(8'hFF, 8'h01, 1'b0, 1'b1);
    add_pair(8'hC8, 8'h64, 1'b0, 1'b1);

    // R9: start together with clear
    add_pair(8'hF0, 8'h33, 1'b1, 1'b0);

    // R1: reset mid-run
    @(negedge clk_i);
    x_i = 8'h12; y_i = 8'h34; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(z_o == 0 && !cout_o && !busy_o && !done_o, "R1 reset mid-run",
        {4'b0, busy_o, done_o, cout_o, 1'b0, z_o}, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    add_pair(8'h00, 8'h00, 1'b0, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule